// File: doc/BRIEF.md
# Dual 32-bit One-Shot/Periodic Timer

This peripheral holds two independent 32-bit up-counters, the low half and the high half, behind a small 32-bit register bus. Each half has a writable count, a period value and a 2-bit run-mode field. The two mode fields sit in one shared control word. A global control word releases each half from reset and selects the timer mode. When a running half's count reaches its period, the half pulses its interrupt for one cycle and restarts from zero. In one-shot mode the half also turns its own mode field back to disabled, so it stops.

A typical system gives the high half an all-ones period, so it runs as a free-running, wrapping time base that software reads at will. The low half then serves as an event timer: software either loads a delay into the period and arms one-shot mode, or leaves the low half running and uses a separate compare register. The compare register raises its own event pulse when the low count passes through the compare value, and counting is not disturbed.

Top module: `dual_timer`

## Requirements
- R1: After reset both counts and the compare value read 0, both periods read 0xFFFFFFFF, the control and global control words read 0, and irq_lo, irq_hi and cmp_evt are low.
- R2: Byte offsets are 0x10 low count, 0x14 high count, 0x18 low period, 0x1C high period, 0x20 control, 0x24 global control, 0x60 compare. Read data is registered: for a read presented in the cycle before edge E, bus_rdata holds from E onward the value the register had just before E.
- R3: A half adds one to its count on every clock edge when three conditions hold: its global release bit is 1, global bits 3:2 equal 01, and its mode field is 1 (one-shot) or 2 (periodic). Mode 0 or 3 holds the count.
- R4: The low half is released by global bit 0 and the high half by global bit 1. While its bit is 0, a half's count is forced to 0, count writes to it are ignored, and its interrupt stays low.
- R5: When a running half's count equals its period at a clock edge, that edge sets its count to 0 and raises its interrupt for exactly one cycle. A half started from count 0 with period P therefore signals P+1 edges after it is enabled.
- R6: A periodic half keeps running after a match, so it signals every P+1 edges.
- R7: A one-shot half clears its own mode field to 0 at its match edge. It signals once and stays at count 0.
- R8: A bus write to a released half's count loads the written value at that edge and takes priority over both counting and a period match in that cycle.
- R9: The low mode field is bits 7:6 of the control word and the high mode field is bits 23:22. A control write, or a one-shot self-clear of the low half, changes neither the high half's mode nor its count.
- R10: With the period at 0xFFFFFFFF, a periodic half wraps from 0xFFFFFFFF to 0, signals at the wrap and keeps counting.
- R11: cmp_evt pulses for one cycle at the edge after the running low count equals the compare value. The low count and the low interrupt go on unaffected.
- R12: When global bits 3:2 hold any value other than 01, both halves keep their counts and do not count. Counting resumes when the value returns to 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_lo | output | 1 | Low-half period match pulse |
| irq_hi | output | 1 | High-half period match pulse |
| cmp_evt | output | 1 | Low-half compare match pulse |

## Verification
A count that is off by one shows on the interrupt pins: the first pulse comes one edge early or late relative to the enabling write, so the bench times every pulse against the edge of that write. A mode field that fails to self-clear, or a high field disturbed by a low-half change, shows in the control word readback at once, and in the high count, which stops advancing between two timed reads. Errors in the reset, timer-mode or load priority state show in the very next count read. A bad compare path shows as a cmp_evt pulse that lands on the wrong edge.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_ONCE   = 2'd1,
      MODE_CYCLIC = 2'd2,
      MODE_RSVD   = 2'd3
   } run_mode_e;

   // Register placement (byte offsets)
   localparam int unsigned CNT_BASE    = 32'h10;
   localparam int unsigned PRD_BASE    = 32'h18;
   localparam int unsigned HALF_STRIDE = 4;
   localparam int unsigned CTL_OFFS    = 32'h20;
   localparam int unsigned GCTL_OFFS   = 32'h24;

   // Mode field positions inside the shared control word
   localparam int unsigned LO_FIELD_LSB = 6;
   localparam int unsigned HI_FIELD_LSB = 22;

   localparam logic [1:0] TMODE_DUAL = 2'b01;

   function automatic int unsigned field_lsb(input int unsigned half);
      return (half == 0) ? LO_FIELD_LSB : HI_FIELD_LSB;
   endfunction

endpackage

// File: rtl/dtmr_half.sv
module dtmr_half
   import dtmr_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             release_i,
   input  logic             dual_i,
   input  logic [1:0]       mode_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o,
   output logic             run_o,
   output logic             stop_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic             hit;

   assign run_o = release_i && dual_i &&
                  ((mode_i == MODE_ONCE) || (mode_i == MODE_CYCLIC));
   assign hit   = run_o && !load_i && (cnt_q == period_i);

   // Request to the owner of the mode field: one-shot expires this edge.
   assign stop_o = hit && (mode_i == MODE_ONCE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else if (!release_i) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
         irq_q <= 1'b0;
      end else if (hit) begin
         cnt_q <= '0;
         irq_q <= 1'b1;
      end else begin
         irq_q <= 1'b0;
         if (run_o) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign count_o = cnt_q;
   assign irq_o   = irq_q;

endmodule

// File: rtl/dtmr_cmp.sv
module dtmr_cmp #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [CNT_W-1:0] value_o,
   output logic             evt_o
);

   logic [CNT_W-1:0] cmp_q;
   logic             evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         evt_q <= 1'b0;
      end else begin
         if (wr_i) cmp_q <= wdata_i;
         evt_q <= run_i && (count_i == cmp_q);
      end
   end

   assign value_o = cmp_q;
   assign evt_o   = evt_q;

endmodule

// File: rtl/dual_timer.sv
module dual_timer
   import dtmr_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter bit          HAS_CMP  = 1'b1,
   parameter int unsigned CMP_OFFS = 32'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_lo,
   output logic              irq_hi,
   output logic              cmp_evt
);

   localparam int unsigned HALVES = 2;
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_OFFS);
   localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(GCTL_OFFS);
   localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(CMP_OFFS);

   // Elaboration-time parameter checks
   if (DATA_W < HI_FIELD_LSB + 2) begin : g_bad_width
      $error("dual_timer: DATA_W cannot hold the high mode field");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("dual_timer: ADDR_W too small for the register offsets");
   end

   logic [HALVES-1:0][1:0]        mode_w;
   logic [HALVES-1:0][DATA_W-1:0] prd_w;
   logic [HALVES-1:0][DATA_W-1:0] cnt_w;
   logic [HALVES-1:0]             load_w;
   logic [HALVES-1:0]             stop_w;
   logic [HALVES-1:0]             run_w;
   logic [HALVES-1:0]             irq_w;
   logic [HALVES-1:0]             release_q;
   logic [1:0]                    tmode_q;
   logic                          dual_w;
   logic                          ctl_wr_w;
   logic                          gctl_wr_w;
   logic                          cmp_wr_w;
   logic [DATA_W-1:0]             cmp_val_w;
   logic                          cmp_evt_w;
   logic [DATA_W-1:0]             rd_mux;
   logic [DATA_W-1:0]             rdata_q;

   assign ctl_wr_w  = bus_wr_en && (bus_addr == A_CTL);
   assign gctl_wr_w = bus_wr_en && (bus_addr == A_GCTL);
   assign cmp_wr_w  = bus_wr_en && (bus_addr == A_CMP);
   assign dual_w    = (tmode_q == TMODE_DUAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         release_q <= '0;
         tmode_q   <= '0;
      end else if (gctl_wr_w) begin
         release_q <= bus_wdata[HALVES-1:0];
         tmode_q   <= bus_wdata[3:2];
      end
   end

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_BASE + HALF_STRIDE * h);
      localparam logic [ADDR_W-1:0] A_PRD = ADDR_W'(PRD_BASE + HALF_STRIDE * h);
      localparam int unsigned       LSB   = field_lsb(h);

      logic [1:0]        mode_r;
      logic [DATA_W-1:0] prd_r;
      logic              prd_wr;

      assign prd_wr    = bus_wr_en && (bus_addr == A_PRD);
      assign load_w[h] = bus_wr_en && (bus_addr == A_CNT);

      // A bus write to the control word wins over a self-clear in the same cycle.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_r <= MODE_OFF;
            prd_r  <= '1;
         end else begin
            if (ctl_wr_w)       mode_r <= bus_wdata[LSB +: 2];
            else if (stop_w[h]) mode_r <= MODE_OFF;
            if (prd_wr)         prd_r  <= bus_wdata;
         end
      end

      assign mode_w[h] = mode_r;
      assign prd_w[h]  = prd_r;

      dtmr_half #(.CNT_W(DATA_W)) u_half (
         .clk        (clk),
         .rst_n      (rst_n),
         .release_i  (release_q[h]),
         .dual_i     (dual_w),
         .mode_i     (mode_r),
         .period_i   (prd_r),
         .load_i     (load_w[h]),
         .load_val_i (bus_wdata),
         .count_o    (cnt_w[h]),
         .irq_o      (irq_w[h]),
         .run_o      (run_w[h]),
         .stop_o     (stop_w[h])
      );
   end

   if (HAS_CMP) begin : g_cmp
      dtmr_cmp #(.CNT_W(DATA_W)) u_cmp (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (cmp_wr_w),
         .wdata_i (bus_wdata),
         .run_i   (run_w[0]),
         .count_i (cnt_w[0]),
         .value_o (cmp_val_w),
         .evt_o   (cmp_evt_w)
      );
   end else begin : g_no_cmp
      assign cmp_val_w = '0;
      assign cmp_evt_w = 1'b0;
   end

   always_comb begin
      rd_mux = '0;
      for (int h = 0; h < HALVES; h++) begin
         if (bus_addr == ADDR_W'(CNT_BASE + HALF_STRIDE * h)) rd_mux = cnt_w[h];
         if (bus_addr == ADDR_W'(PRD_BASE + HALF_STRIDE * h)) rd_mux = prd_w[h];
      end
      if (bus_addr == A_CTL) begin
         for (int h = 0; h < HALVES; h++) rd_mux[field_lsb(h) +: 2] = mode_w[h];
      end
      if (bus_addr == A_GCTL) rd_mux[3:0] = {tmode_q, release_q};
      if (HAS_CMP && (bus_addr == A_CMP)) rd_mux = cmp_val_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata_q <= '0;
      else if (bus_rd_en) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;
   assign irq_lo    = irq_w[0];
   assign irq_hi    = irq_w[1];
   assign cmp_evt   = cmp_evt_w;

endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
   import dtmr_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_lo,
   input logic              irq_hi,
   input logic              cmp_evt,
   input logic [1:0][W-1:0] cnt_i,
   input logic [W-1:0]      prd_lo_i,
   input logic [1:0]        mode_lo_i,
   input logic              release_lo_i,
   input logic              run_lo_i,
   input logic              load_lo_i,
   input logic              ctl_wr_i,
   input logic [W-1:0]      load_val_i,
   input logic [W-1:0]      cmp_val_i
);

   // R3: a running low half steps by exactly one
   a_r3_step_lo : assert property (@(posedge clk) disable iff (!rst_n)
      (run_lo_i && !load_lo_i && (cnt_i[0] != prd_lo_i)) |=> (cnt_i[0] == $past(cnt_i[0]) + W'(1)));

   // R4: a low half held in reset sits at zero and stays quiet
   a_r4_hold_lo : assert property (@(posedge clk) disable iff (!rst_n)
      !release_lo_i |=> ((cnt_i[0] == '0) && !irq_lo));

   // R5: each interrupt pulse coincides with a count of zero
   a_r5_irq_lo_zero : assert property (@(posedge clk) disable iff (!rst_n)
      irq_lo |-> (cnt_i[0] == '0));

   a_r5_irq_hi_zero : assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi |-> (cnt_i[1] == '0));

   // R7: a one-shot expiry leaves the low mode field disabled
   a_r7_self_stop_lo : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lo && !$past(ctl_wr_i) && ($past(mode_lo_i) == MODE_ONCE)) |-> (mode_lo_i == MODE_OFF));

   // R8: a count write to a released half lands as written
   a_r8_load_lo : assert property (@(posedge clk) disable iff (!rst_n)
      (load_lo_i && release_lo_i) |=> (cnt_i[0] == $past(load_val_i)));

   // R11: a compare pulse follows a running count equal to the compare value
   a_r11_cmp_match : assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt |-> $past(run_lo_i && (cnt_i[0] == cmp_val_i)));

endmodule

bind dual_timer dual_timer_chk #(.W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_lo       (irq_lo),
   .irq_hi       (irq_hi),
   .cmp_evt      (cmp_evt),
   .cnt_i        (cnt_w),
   .prd_lo_i     (prd_w[0]),
   .mode_lo_i    (mode_w[0]),
   .release_lo_i (release_q[0]),
   .run_lo_i     (run_w[0]),
   .load_lo_i    (load_w[0]),
   .ctl_wr_i     (ctl_wr_w),
   .load_val_i   (bus_wdata),
   .cmp_val_i    (cmp_val_w)
);

// File: tb/tb_dual_timer.sv
`timescale 1ns/1ps
module tb_dual_timer;

   localparam int DW = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr_en = 1'b0;
   logic          bus_rd_en = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_lo;
   logic          irq_hi;
   logic          cmp_evt;

   always #2.5 clk = ~clk;

   dual_timer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr_en (bus_wr_en),
      .bus_rd_en (bus_rd_en),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_lo    (irq_lo),
      .irq_hi    (irq_hi),
      .cmp_evt   (cmp_evt)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int last_edge = 0;

   int lo_t[$];
   int hi_t[$];
   int cmp_t[$];

   typedef struct {
      logic [31:0] expv;
      string       tag;
   } exp_t;
   exp_t sb[$];

   logic exp_flag = 1'b0;
   logic exp_d = 1'b0;
   always @(posedge clk) exp_d <= exp_flag;

   function automatic void check(input bit ok, input string tag, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endfunction

   // Monitor: timestamps pulses and pops scoreboard items as read data appears
   always @(negedge clk) begin
      if (irq_lo)  lo_t.push_back(cyc);
      if (irq_hi)  hi_t.push_back(cyc);
      if (cmp_evt) cmp_t.push_back(cyc);
      if (exp_d) begin
         exp_t item;
         if (sb.size() == 0) check(1'b0, "scoreboard underflow", 0, 1);
         else begin
            item = sb.pop_front();
            check(bus_rdata === item.expv, item.tag, bus_rdata, item.expv);
         end
      end
   end

   // Driver tasks: all start and end at a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr_en = 1'b0;
      last_edge = cyc;
   endtask

   task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
      exp_t item;
      item.expv = e;
      item.tag  = tag;
      sb.push_back(item);
      bus_rd_en = 1'b1; exp_flag = 1'b1; bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      bus_rd_en = 1'b0; exp_flag = 1'b0;
      last_edge = cyc;
   endtask

   task automatic rd_get(input logic [7:0] a, output logic [31:0] v, output int edge_o);
      bus_rd_en = 1'b1; bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      bus_rd_en = 1'b0;
      v = bus_rdata;
      edge_o = cyc;
      last_edge = cyc;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] va, vb, v;
      int ea, eb, e0, er;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2: reset contents through the register map
      check(!irq_lo && !irq_hi && !cmp_evt, "R1 outputs idle after reset",
            {irq_lo, irq_hi, cmp_evt}, 0);
      rd_exp(8'h10, 32'h0, "R1 low count");
      rd_exp(8'h14, 32'h0, "R1 high count");
      rd_exp(8'h18, 32'hFFFF_FFFF, "R1 low period");
      rd_exp(8'h1C, 32'hFFFF_FFFF, "R1 high period");
      rd_exp(8'h20, 32'h0, "R1 control");
      rd_exp(8'h24, 32'h0, "R1 global control");
      rd_exp(8'h60, 32'h0, "R1 compare");

      // R3: modes 0 and 3 hold the count
      wr(8'h24, 32'h7);
      idle(4);
      rd_exp(8'h10, 32'h0, "R3 mode 0 holds");
      wr(8'h20, 32'h0000_00C0);
      idle(4);
      rd_exp(8'h10, 32'h0, "R3 mode 3 holds");

      // R5 / R6: periodic low half with period 9
      wr(8'h18, 32'd9);
      lo_t.delete();
      wr(8'h20, 32'h0080_0080);
      e0 = last_edge;
      idle(25);
      if (lo_t.size() >= 2) begin
         check(lo_t[0] - e0 == 10, "R5 first periodic event", lo_t[0] - e0, 10);
         check(lo_t[1] - lo_t[0] == 10, "R6 periodic interval", lo_t[1] - lo_t[0], 10);
      end else check(1'b0, "R6 periodic events seen", lo_t.size(), 2);
      rd_get(8'h14, va, ea);
      idle(6);
      rd_get(8'h14, vb, eb);
      check((vb - va) == 32'(eb - ea), "R3 high half counts", vb - va, eb - ea);

      // R7 / R9: one-shot low half, high half running periodic
      wr(8'h20, 32'h0080_0000);
      wr(8'h10, 32'h0);
      wr(8'h18, 32'd4);
      lo_t.delete();
      rd_get(8'h14, va, ea);
      wr(8'h20, 32'h0080_0040);
      e0 = last_edge;
      idle(20);
      check(lo_t.size() == 1, "R7 one-shot signals once", lo_t.size(), 1);
      if (lo_t.size() >= 1)
         check(lo_t[0] - e0 == 5, "R5 one-shot delay", lo_t[0] - e0, 5);
      rd_exp(8'h20, 32'h0080_0000, "R7 low field cleared and R9 high field kept");
      rd_exp(8'h10, 32'h0, "R7 low half parked at zero");
      rd_get(8'h14, vb, eb);
      check((vb - va) == 32'(eb - ea), "R9 high half undisturbed", vb - va, eb - ea);

      // R8: count writes take priority over counting and matching
      wr(8'h18, 32'd100);
      wr(8'h20, 32'h0080_0080);
      idle(3);
      wr(8'h10, 32'd50);
      rd_exp(8'h10, 32'd50, "R8 count write lands");
      lo_t.delete();
      wr(8'h10, 32'd100);
      e0 = last_edge;
      rd_exp(8'h10, 32'd100, "R8 written value held one cycle");
      rd_exp(8'h10, 32'd0, "R5 reload to zero on match");
      if (lo_t.size() >= 1)
         check(lo_t[0] == e0 + 1, "R5 match at written period", lo_t[0] - e0, 1);
      else check(1'b0, "R5 match at written period", 0, 1);

      // R4: low half held in reset
      wr(8'h24, 32'h6);
      lo_t.delete();
      wr(8'h10, 32'd77);
      rd_exp(8'h10, 32'h0, "R4 count held at zero");
      idle(120);
      check(lo_t.size() == 0, "R4 no event while in reset", lo_t.size(), 0);
      wr(8'h24, 32'h7);

      // R10: all-ones period wraps
      wr(8'h20, 32'h0080_0000);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h10, 32'hFFFF_FFFD);
      lo_t.delete();
      wr(8'h20, 32'h0080_0080);
      e0 = last_edge;
      rd_exp(8'h10, 32'hFFFF_FFFD, "R10 count near the top");
      idle(8);
      if (lo_t.size() >= 1)
         check(lo_t[0] - e0 == 3, "R10 wrap event", lo_t[0] - e0, 3);
      else check(1'b0, "R10 wrap event", 0, 1);
      rd_get(8'h10, v, er);
      check(v == 32'(er - 1 - (e0 + 3)), "R10 counting past wrap", v, er - 1 - (e0 + 3));

      // R11: compare event on a running low half
      wr(8'h20, 32'h0080_0000);
      wr(8'h10, 32'h0);
      wr(8'h60, 32'h20);
      wr(8'h18, 32'h40);
      lo_t.delete();
      cmp_t.delete();
      wr(8'h20, 32'h0080_0080);
      e0 = last_edge;
      idle(100);
      if (cmp_t.size() >= 2) begin
         check(cmp_t[0] - e0 == 33, "R11 compare event timing", cmp_t[0] - e0, 33);
         check(cmp_t[1] - cmp_t[0] == 65, "R11 compare repeats with period", cmp_t[1] - cmp_t[0], 65);
      end else check(1'b0, "R11 compare events seen", cmp_t.size(), 2);
      if (lo_t.size() >= 1)
         check(lo_t[0] - e0 == 65, "R11 period match unaffected", lo_t[0] - e0, 65);
      else check(1'b0, "R11 period match unaffected", 0, 1);
      rd_exp(8'h60, 32'h20, "R2 compare readback");

      // R12: timer mode other than 01 freezes the halves
      wr(8'h24, 32'hB);
      rd_exp(8'h24, 32'hB, "R2 global control readback");
      rd_get(8'h14, va, ea);
      idle(5);
      rd_get(8'h14, vb, eb);
      check(vb == va, "R12 frozen outside dual mode", vb, va);
      wr(8'h24, 32'h7);
      rd_get(8'h14, va, ea);
      idle(5);
      rd_get(8'h14, vb, eb);
      check((vb - va) == 32'(eb - ea), "R12 counting resumes", vb - va, eb - ea);

      check(hi_t.size() == 0, "R10 high half far from its wrap", hi_t.size(), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule